// File: doc/BRIEF.md
# Snoop-Aware Load-Reserve Reservation Unit

This block holds one load-reserve reservation for a single cache line, identified by the physical line address. Other bus agents' writes are watched on a snoop port. A qualifying write to the reserved line removes the reservation. This also applies in the first two pipeline clocks of a load-reserve, before the physical address is known, and while the block is pending on late load data.

A store-conditional is checked one clock after it is accepted. If the reservation still covers its line, the block runs a single bus-master write. The write is abandoned at once if the reservation disappears while the bus cycle is still open. The cache arrays, tag lookup and address translation are outside the block. The tag array supplies the snoop's hit and way, the translation stage supplies the physical address in the second clock, and the data path reports when load data has arrived.

Requests use a two-stage timing:
- Clock 0 carries the operation flags, the cache index and the way.
- Clock 1 carries the physical address and the cache hit flag.

Requests are issued only while no store-conditional is in progress.

Top module: `lr_resv_unit`

## Requirements
- R1: After synchronous reset, `m_cyc`, `m_stb`, `m_we`, `cache_we` and `sc_done` are low, and no reservation exists, so a store-conditional fails.
- R2: Reservation matching uses address bits from `LINE_W` upward only. A store-conditional to another offset in the same line can pass, and one to a different line fails.
- R3: A snooped write counts only when `snp_cyc`, `snp_stb` and `snp_we` are all high. It is ignored in any clock where `m_cyc` is high and `m_stall` is low.
- R4: A load-reserve (`req_load`=1, `req_reserve`=1, `req_first`=1) records the line at the end of clock 1. The reservation becomes usable when `ld_data_ok` pulses, either in clock 1 or later. A matching snoop while the data is outstanding cancels it.
- R5: For a two-part load-reserve, only the part with `req_first`=1 arms the reservation. A matching snoop between the parts kills it, and the second part (`req_first`=0) does not re-arm it.
- R6: A snoop in clock 0 of a load-reserve cancels that reservation when three things hold: `snp_tag_hit` is high, `snp_tag_way` equals `req_way`, and snoop address bits [LINE_W+IDX_W-1:LINE_W] equal `req_index`.
- R7: A matching snoop in clock 1 of a load-reserve, when the line has just been recorded, cancels the reservation one clock later.
- R8: A store-conditional whose check fails returns `sc_done`=1 with `sc_pass`=0. `m_cyc` and `m_stb` are low in that clock, and the reservation is cleared.
- R9: A passing store-conditional raises `m_cyc`, `m_stb` and `m_we`. It drops `m_stb` after a non-stalled clock, and on `m_ack` it ends the cycle and gives a one-clock `sc_done` with `sc_pass`=1.
- R10: A qualifying snoop to the reserved line while the store-conditional's bus cycle is open and stalled aborts the write with a fail result. No `cache_we` is produced.
- R11: A passing store-conditional with `req_last`=0 keeps the reservation. With `req_last`=1, it clears the reservation on acknowledge.
- R12: `cache_we` pulses once for a passing store-conditional with `s1_hit`=1, in the clock after the bus accepts the write. It never pulses for a miss.
- R13: A snoop kill in the same clock as a reservation being set takes priority, and the reservation is left unusable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request in clock 0 |
| req_load | input | 1 | 1 = load-reserve, 0 = store-conditional |
| req_reserve | input | 1 | Request is a reserve-type operation |
| req_first | input | 1 | First part of a two-part access (1 for single) |
| req_last | input | 1 | Last part of a two-part access (1 for single) |
| req_index | input | IDX_W | Cache index of the request, clock 0 |
| req_way | input | WAY_W | Cache way of the request, clock 0 |
| s1_raddr | input | ADDR_W | Physical address, clock 1 |
| s1_hit | input | 1 | Cache hit flag, clock 1 |
| ld_data_ok | input | 1 | Load data arrived |
| snp_cyc | input | 1 | Snoop bus cycle |
| snp_stb | input | 1 | Snoop bus strobe |
| snp_we | input | 1 | Snoop bus write enable |
| snp_addr | input | ADDR_W | Snoop physical address |
| snp_tag_hit | input | 1 | Tag lookup hit for the snoop address |
| snp_tag_way | input | WAY_W | Way hit by the snoop address |
| m_stall | input | 1 | Master bus stall |
| m_ack | input | 1 | Master bus acknowledge |
| m_cyc | output | 1 | Master bus cycle |
| m_stb | output | 1 | Master bus strobe |
| m_we | output | 1 | Master bus write enable |
| cache_we | output | 1 | Cache data write pulse for a store-conditional hit |
| sc_done | output | 1 | Store-conditional completion pulse |
| sc_pass | output | 1 | Store-conditional result, valid with `sc_done` |

## Verification
The hardest situations to reach are the narrow windows. One is a snoop in clock 0 or clock 1 of a load-reserve, before the line address is recorded. The other is a snoop that arrives while the conditional write is stalled on the bus, as opposed to one that arrives after the bus has accepted it.

The bench reaches these by putting the snoop at an exact clock offset from the request, and by holding `m_stall` for a chosen number of clocks. A random loop then sweeps snoop phase, snoop line, load-data latency and target line. Each outcome is predicted by a bench function.

// File: rtl/lr_resv_unit.sv
module lr_resv_unit #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 6,
  parameter int IDX_W  = 6,
  parameter int WAY_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_load,
  input  logic              req_reserve,
  input  logic              req_first,
  input  logic              req_last,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [WAY_W-1:0]  req_way,
  input  logic [ADDR_W-1:0] s1_raddr,
  input  logic              s1_hit,
  input  logic              ld_data_ok,
  input  logic              snp_cyc,
  input  logic              snp_stb,
  input  logic              snp_we,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              snp_tag_hit,
  input  logic [WAY_W-1:0]  snp_tag_way,
  input  logic              m_stall,
  input  logic              m_ack,
  output logic              m_cyc,
  output logic              m_stb,
  output logic              m_we,
  output logic              cache_we,
  output logic              sc_done,
  output logic              sc_pass
);
  localparam int LA_W = ADDR_W - LINE_W;

  typedef enum logic {ST_IDLE, ST_SC} st_t;
  st_t state;

  logic [LA_W-1:0] snp_line, s1_line, rsv_line, snp_q_line, sc_line;
  logic snp_act, snp_q_v, rsv_valid, rsv_pend, rsv_live;
  logic kill_now, kill_prev, kill, poison0;
  logic s1_v, s1_ld, s1_first, s1_last, s1_poison;
  logic lr_cap, sc_go, sc_bad, sc_last, sc_hit;
  logic unused_low;

  assign snp_line   = snp_addr[ADDR_W-1:LINE_W];
  assign s1_line    = s1_raddr[ADDR_W-1:LINE_W];
  assign unused_low = ^{snp_addr[LINE_W-1:0], s1_raddr[LINE_W-1:0]};

  assign snp_act   = snp_cyc & snp_stb & snp_we & ~(m_cyc & ~m_stall);
  assign rsv_live  = rsv_valid | rsv_pend;
  assign kill_now  = snp_act & rsv_live & (snp_line == rsv_line);
  assign kill_prev = snp_q_v & rsv_live & (snp_q_line == rsv_line);
  assign kill      = kill_now | kill_prev;

  assign poison0 = req_valid & req_reserve & req_load & snp_act & snp_tag_hit &
                   (snp_tag_way == req_way) &
                   (snp_addr[LINE_W +: IDX_W] == req_index);

  assign lr_cap = s1_v & s1_ld & s1_first;
  assign sc_go  = s1_v & ~s1_ld & (state == ST_IDLE);
  assign sc_bad = (state == ST_SC) &
                  (~rsv_valid | kill_now | (sc_line != rsv_line));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      snp_q_v    <= 1'b0;
      snp_q_line <= '0;
      rsv_valid  <= 1'b0;
      rsv_pend   <= 1'b0;
      rsv_line   <= '0;
      s1_v       <= 1'b0;
      s1_ld      <= 1'b0;
      s1_first   <= 1'b0;
      s1_last    <= 1'b0;
      s1_poison  <= 1'b0;
      sc_line    <= '0;
      sc_last    <= 1'b0;
      sc_hit     <= 1'b0;
      m_cyc      <= 1'b0;
      m_stb      <= 1'b0;
      m_we       <= 1'b0;
      cache_we   <= 1'b0;
      sc_done    <= 1'b0;
      sc_pass    <= 1'b0;
    end else begin
      snp_q_v    <= snp_act;
      snp_q_line <= snp_line;
      s1_v       <= req_valid & req_reserve;
      s1_ld      <= req_load;
      s1_first   <= req_first;
      s1_last    <= req_last;
      s1_poison  <= poison0;
      cache_we   <= 1'b0;
      sc_done    <= 1'b0;
      sc_pass    <= 1'b0;

      if (ld_data_ok && rsv_pend) begin
        rsv_valid <= 1'b1;
        rsv_pend  <= 1'b0;
      end
      if (lr_cap) begin
        rsv_line  <= s1_line;
        rsv_valid <= ld_data_ok & ~s1_poison;
        rsv_pend  <= ~ld_data_ok & ~s1_poison;
      end

      case (state)
        ST_IDLE: begin
          if (sc_go) begin
            state   <= ST_SC;
            sc_line <= s1_line;
            sc_last <= s1_last;
            sc_hit  <= s1_hit;
          end
        end
        ST_SC: begin
          if (sc_bad) begin
            state     <= ST_IDLE;
            m_cyc     <= 1'b0;
            m_stb     <= 1'b0;
            m_we      <= 1'b0;
            sc_done   <= 1'b1;
            rsv_valid <= 1'b0;
          end else if (!m_cyc) begin
            m_cyc <= 1'b1;
            m_stb <= 1'b1;
            m_we  <= 1'b1;
          end else begin
            if (m_stb && !m_stall) begin
              m_stb    <= 1'b0;
              cache_we <= sc_hit;
            end
            if (m_ack) begin
              state   <= ST_IDLE;
              m_cyc   <= 1'b0;
              m_stb   <= 1'b0;
              m_we    <= 1'b0;
              sc_done <= 1'b1;
              sc_pass <= 1'b1;
              if (sc_last) rsv_valid <= 1'b0;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase

      if (kill) begin
        rsv_valid <= 1'b0;
        rsv_pend  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lr_resv_unit_chk.sv
module lr_resv_unit_chk (
  input logic clk,
  input logic rst,
  input logic m_cyc,
  input logic m_stb,
  input logic m_stall,
  input logic m_ack,
  input logic cache_we,
  input logic sc_done,
  input logic sc_pass
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!m_cyc && !sc_done && !cache_we));

  a_r9_stb_in_cyc: assert property (@(posedge clk) disable iff (rst)
    m_stb |-> m_cyc);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    sc_done |=> !sc_done);

  a_r9_pass_after_ack: assert property (@(posedge clk) disable iff (rst)
    (sc_done && sc_pass) |-> $past(m_ack && m_cyc));

  a_r9_pass_with_done: assert property (@(posedge clk) disable iff (rst)
    sc_pass |-> sc_done);

  a_r8_fail_drops_bus: assert property (@(posedge clk) disable iff (rst)
    (sc_done && !sc_pass) |-> (!m_cyc && !m_stb));

  a_r12_we_after_accept: assert property (@(posedge clk) disable iff (rst)
    cache_we |-> $past(m_stb && !m_stall));
endmodule

bind lr_resv_unit lr_resv_unit_chk chk_i (
  .clk(clk), .rst(rst), .m_cyc(m_cyc), .m_stb(m_stb), .m_stall(m_stall),
  .m_ack(m_ack), .cache_we(cache_we), .sc_done(sc_done), .sc_pass(sc_pass)
);

// File: tb/lr_resv_unit_tb_top.sv
module lr_resv_unit_tb_top;
  localparam int AW = 32, LW = 6, IW = 6, WW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid, req_load, req_reserve, req_first, req_last;
  logic [IW-1:0] req_index;
  logic [WW-1:0] req_way, snp_tag_way;
  logic [AW-1:0] s1_raddr, snp_addr;
  logic s1_hit, ld_data_ok, snp_cyc, snp_stb, snp_we, snp_tag_hit;
  logic m_stall, m_ack, m_cyc, m_stb, m_we, cache_we, sc_done, sc_pass;

  int total = 0, fails = 0;
  int snp_kind = 0;

  always #10 clk = ~clk;

  lr_resv_unit #(.ADDR_W(AW), .LINE_W(LW), .IDX_W(IW), .WAY_W(WW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_load(req_load),
    .req_reserve(req_reserve), .req_first(req_first), .req_last(req_last),
    .req_index(req_index), .req_way(req_way), .s1_raddr(s1_raddr),
    .s1_hit(s1_hit), .ld_data_ok(ld_data_ok), .snp_cyc(snp_cyc),
    .snp_stb(snp_stb), .snp_we(snp_we), .snp_addr(snp_addr),
    .snp_tag_hit(snp_tag_hit), .snp_tag_way(snp_tag_way),
    .m_stall(m_stall), .m_ack(m_ack), .m_cyc(m_cyc), .m_stb(m_stb),
    .m_we(m_we), .cache_we(cache_we), .sc_done(sc_done), .sc_pass(sc_pass));

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mkaddr(input int line);
    logic [AW-1:0] a;
    a = AW'(line) << LW;
    a[LW-1:0] = LW'($urandom);
    return a;
  endfunction

  function automatic bit exp_sc(input int lr_line, input int sc_line,
                                input int sp, input int sline);
    return (lr_line == sc_line) && !(sp >= 0 && sline == lr_line);
  endfunction

  task automatic clear_req();
    req_valid = 0; req_load = 0; req_reserve = 0; req_first = 0; req_last = 0;
    req_index = '0; req_way = '0; s1_raddr = '0; s1_hit = 0; ld_data_ok = 0;
    snp_cyc = 0; snp_stb = 0; snp_we = 0; snp_addr = '0;
    snp_tag_hit = 0; snp_tag_way = '0;
  endtask

  task automatic put_snoop(input int line, input bit th, input int way);
    snp_cyc = 1; snp_stb = (snp_kind != 2); snp_we = (snp_kind != 1);
    snp_addr = mkaddr(line); snp_tag_hit = th; snp_tag_way = WW'(way);
  endtask

  task automatic lr_op(input int line, input bit first, input int dly,
                       input int sp, input int sline);
    int last_t;
    last_t = ((1 + dly) > sp ? (1 + dly) : sp) + 2;
    for (int t = 0; t <= last_t; t++) begin
      @(negedge clk);
      clear_req();
      if (t == 0) begin
        req_valid = 1; req_load = 1; req_reserve = 1; req_first = first;
        req_last = 1; req_index = IW'(line); req_way = WW'(line % 4);
      end
      if (t == 1) begin s1_raddr = mkaddr(line); s1_hit = (dly == 0); end
      if (t == 1 + dly) ld_data_ok = 1;
      if (t == sp) put_snoop(sline, (t == 0) && (sline == line), line % 4);
    end
    @(negedge clk);
    clear_req();
  endtask

  task automatic sc_op(input int line, input bit last, input bit hit,
                       input int stall_n, input int ack_d, input int sp,
                       input int sline, input bit exp_pass, input int exp_we,
                       input string rq);
    int stall_left, acc_t, we_cnt, cyc_done;
    bit got, pass;
    stall_left = stall_n; acc_t = -1; we_cnt = 0; got = 0; pass = 0;
    cyc_done = 0;
    for (int t = 0; t < 40 && !got; t++) begin
      @(negedge clk);
      clear_req();
      if (cache_we) we_cnt++;
      if (sc_done) begin
        got = 1; pass = sc_pass; cyc_done = m_cyc | m_stb;
        m_stall = 0; m_ack = 0;
      end else begin
        if (t == 0) begin
          req_valid = 1; req_load = 0; req_reserve = 1; req_first = 1;
          req_last = last; req_index = IW'(line); req_way = WW'(line % 4);
        end
        if (t == 1) begin s1_raddr = mkaddr(line); s1_hit = hit; end
        if (t == sp) put_snoop(sline, 0, 0);
        m_stall = 0;
        if (m_cyc && m_stb && stall_left > 0) begin
          m_stall = 1; stall_left--;
        end else if (m_cyc && m_stb && acc_t < 0) acc_t = t;
        m_ack = (acc_t >= 0) && (t >= acc_t + ack_d) && m_cyc;
      end
    end
    @(negedge clk);
    if (cache_we) we_cnt++;
    clear_req(); m_stall = 0; m_ack = 0;
    chk(got, rq, "sc_done seen", got, 1);
    chk(pass == exp_pass, rq, "sc_pass", pass, exp_pass);
    chk(we_cnt == exp_we, rq, "cache_we count", we_cnt, exp_we);
    chk(cyc_done == 0, rq, "bus idle at done", cyc_done, 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; clear_req(); m_stall = 0; m_ack = 0;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int a, b, c, sp, dly;
    bit hit, ep;
    clear_req(); m_stall = 0; m_ack = 0;
    do_reset();
    @(negedge clk);
    chk(!m_cyc && !m_stb && !m_we, "R1", "bus after reset", m_cyc, 0);
    chk(!sc_done && !cache_we, "R1", "pulses after reset", sc_done, 0);
    sc_op(10, 1, 1, 0, 1, -1, 0, 0, 0, "R1");

    lr_op(10, 1, 0, -1, 0);
    sc_op(10, 1, 1, 1, 1, -1, 0, 1, 1, "R2 R9 R12");
    sc_op(10, 1, 1, 0, 1, -1, 0, 0, 0, "R11");

    lr_op(10, 1, 0, -1, 0);
    sc_op(11, 1, 1, 0, 1, -1, 0, 0, 0, "R2");
    sc_op(10, 1, 1, 0, 1, -1, 0, 0, 0, "R8");

    lr_op(12, 1, 3, 3, 12);
    sc_op(12, 1, 1, 0, 1, -1, 0, 0, 0, "R4");
    lr_op(12, 1, 3, -1, 0);
    sc_op(12, 1, 0, 0, 2, -1, 0, 1, 0, "R4 R12");

    lr_op(13, 1, 0, 0, 13);
    sc_op(13, 1, 1, 0, 1, -1, 0, 0, 0, "R6");
    lr_op(14, 1, 0, 1, 14);
    sc_op(14, 1, 1, 0, 1, -1, 0, 0, 0, "R7");

    lr_op(15, 1, 0, -1, 0);
    lr_op(15, 1, 0, 1, 15);
    sc_op(15, 1, 1, 0, 1, -1, 0, 0, 0, "R13");

    lr_op(16, 1, 0, 2, 16);
    lr_op(16, 0, 0, -1, 0);
    sc_op(16, 1, 1, 0, 1, -1, 0, 0, 0, "R5");
    lr_op(17, 1, 0, -1, 0);
    lr_op(17, 0, 0, -1, 0);
    sc_op(17, 0, 1, 0, 1, -1, 0, 1, 1, "R5 R11");
    sc_op(17, 1, 1, 0, 1, -1, 0, 1, 1, "R11");
    sc_op(17, 1, 1, 0, 1, -1, 0, 0, 0, "R11");

    lr_op(18, 1, 0, -1, 0);
    sc_op(18, 1, 1, 3, 1, 4, 18, 0, 0, "R10");
    lr_op(19, 1, 0, -1, 0);
    sc_op(19, 1, 1, 0, 3, 5, 19, 1, 1, "R3 own-cycle mask");
    snp_kind = 1;
    lr_op(20, 1, 0, 2, 20);
    sc_op(20, 1, 0, 0, 1, -1, 0, 1, 0, "R3 no-we");
    snp_kind = 2;
    lr_op(21, 1, 0, 2, 21);
    sc_op(21, 1, 0, 0, 1, -1, 0, 1, 0, "R3 no-stb");
    snp_kind = 0;

    do_reset();
    void'($urandom(32'd1234));
    for (int i = 0; i < 40; i++) begin
      a = 32 + ($urandom % 4);
      b = ($urandom % 2) ? a : 32 + ($urandom % 4);
      c = ($urandom % 4) ? a : 32 + ($urandom % 4);
      sp = int'($urandom % 6) - 1;
      dly = $urandom % 3;
      hit = $urandom % 2;
      ep = exp_sc(a, c, sp, b);
      lr_op(a, 1, dly, sp, b);
      sc_op(c, 1, hit, $urandom % 3, 1 + ($urandom % 2), -1, 0, ep,
            (ep && hit) ? 1 : 0, "R4 R6 R7 random");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule